// File: doc/BRIEF.md
# Preamble Correlating Byte Aligner

This block sits behind a serial-to-parallel converter that delivers bytes with an arbitrary bit boundary. It keeps the most recent 40 received bits in a window and runs eight 32-bit correlators over it. Each correlator reads the window one bit further along than the previous one. When a correlator's agreement with the frame preamble reaches a programmable threshold, its index gives the bit offset of the true byte boundary. A first detection only sets up a candidate. Lock is taken when the same offset wins again exactly one frame (260 bytes) later.

Once locked, the block emits realigned and descrambled payload bytes. These are the 256 bytes that follow each preamble. The first byte of every frame carries a start flag for the downstream codeword decoder. Both byte streams use valid/ready handshakes. An input byte is taken only when `s_valid` and `s_ready` are both high. `s_ready` is high whenever the output register is empty or is being drained in the same cycle. While `m_valid` is high and `m_ready` is low, the output byte and flag stay frozen and no input is taken. Threshold, lock flag and offset are plain signals.

Top module: `pre_align`

## Requirements
- R1: Correlator k (k = 0..7) compares the 32 window bits that begin k bits after the oldest window bit against the preamble word (first bit = word bit 31). Its score is the number of equal bits, and it hits when score >= `thr`.
- R2: When several correlators hit in one window, the one with the highest score supplies the offset, with ties going to the lowest k; `align_off` reports the locked offset.
- R3: A hit while hunting makes a candidate. Lock needs a hit with the same winning k exactly 260 accepted bytes later. A hit at another distance, or with another k, replaces the candidate. No hit at that distance returns the block to hunting.
- R4: Before lock nothing is emitted. The first emitted byte is the first byte after the confirming preamble.
- R5: An emitted byte is the 8 stream bits that directly follow the preamble (or the previous payload byte), first stream bit in bit 7. Stream bits enter MSB first within each input byte.
- R6: Payload byte j (0..255) of a frame is XORed with byte (j mod 4) of the 32-bit scrambling word, where byte 0 is bits 31:24. The index restarts at 0 after every preamble.
- R7: Each frame emits exactly 256 bytes. `m_sof` is 1 on byte 0 and 0 on the rest. The four preamble bytes are never emitted.
- R8: While locked, the preamble is checked only at its scheduled position, using the locked correlator. One miss keeps lock and the frame is still emitted. A second consecutive miss drops lock and emits nothing for that frame. A good preamble clears the miss history.
- R9: `s_ready` equals `!m_valid || m_ready`. A stalled output byte and its flag stay unchanged until taken.
- R10: After reset `m_valid` and `locked` are 0 and `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr | input | 6 | Minimum agreement count for a hit |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted this cycle when valid |
| s_data | input | 8 | Input byte, first received bit in bit 7 |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream takes the output byte |
| m_data | output | 8 | Realigned, descrambled payload byte |
| m_sof | output | 1 | First payload byte of a frame |
| locked | output | 1 | Alignment locked |
| align_off | output | 3 | Candidate or locked bit offset |

## Verification
The assertions rely on `thr` being changed only while reset is held. The winner-score and lock-entry properties compare against it. They also rely on the upstream source never withdrawing a byte in a way that matters to lock timing. The block counts only accepted bytes, so input gaps are harmless. The stimulus writes `thr` only inside the reset sequence. It forms each test stream as a bit sequence with the preamble placed at a chosen bit offset and random-looking payload. At the thresholds used, the payload is unlikely to produce a stray hit that would disturb candidate tracking.

// File: rtl/psync_pkg.sv
package psync_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_TRACK   = 2'd2
  } sync_st_e;
endpackage

// File: rtl/psync_corr.sv
module psync_corr #(
  parameter int PW = 32,
  parameter int SW = 6,
  parameter logic [PW-1:0] PATTERN = '0
) (
  input  logic [PW-1:0] slice,
  output logic [SW-1:0] score
);
  logic [PW-1:0] diff;
  logic [SW-1:0] nmiss;

  always_comb begin
    diff  = slice ^ PATTERN;
    nmiss = '0;
    for (int i = 0; i < PW; i++) nmiss = nmiss + SW'(diff[i]);
    score = SW'(PW) - nmiss;
  end
endmodule

// File: rtl/psync_pick.sv
module psync_pick #(
  parameter int N  = 8,
  parameter int SW = 6,
  parameter int KW = 3
) (
  input  logic [N-1:0][SW-1:0] scores,
  input  logic [SW-1:0]        thr,
  output logic                 hit,
  output logic [KW-1:0]        best_k,
  output logic [SW-1:0]        best_s
);
  always_comb begin
    best_s = scores[0];
    best_k = '0;
    // strict compare keeps the lowest index on a tie
    for (int i = 1; i < N; i++) begin
      if (scores[i] > best_s) begin
        best_s = scores[i];
        best_k = KW'(i);
      end
    end
    hit = (best_s >= thr);
  end
endmodule

// File: rtl/psync_shift.sv
module psync_shift #(
  parameter int BW = 8,
  parameter int KW = 3
) (
  input  logic [2*BW-1:0] bits,
  input  logic [KW-1:0]   k,
  output logic [BW-1:0]   q
);
  logic [BW-1:0] opt [BW];

  for (genvar g = 0; g < BW; g++) begin : g_tap
    assign opt[g] = bits[2*BW-1-g -: BW];
  end

  assign q = opt[k];
endmodule

// File: rtl/pre_align.sv
module pre_align #(
  parameter int PRE_BITS = 32,
  parameter logic [PRE_BITS-1:0] PRE_WORD = 32'hE4A62F1D,
  parameter int SCR_BITS = 32,
  parameter logic [SCR_BITS-1:0] SCR_WORD = 32'h9B3CD058,
  parameter int FRAME_BYTES = 260,
  parameter int DATA_BYTES = 256,
  localparam int BW = 8,
  localparam int KW = $clog2(BW),
  localparam int SW = $clog2(PRE_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] thr,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [BW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [BW-1:0] m_data,
  output logic          m_sof,
  output logic          locked,
  output logic [KW-1:0] align_off
);
  import psync_pkg::*;

  localparam int WIN   = PRE_BITS + BW;
  localparam int CW    = $clog2(FRAME_BYTES + 1);
  localparam int SCR_N = SCR_BITS / BW;
  localparam int SIW   = $clog2(SCR_N);
  localparam logic [CW-1:0] FRAME_C = CW'(FRAME_BYTES);
  localparam logic [CW-1:0] DATA_C  = CW'(DATA_BYTES);
  localparam logic [SCR_N-1:0][BW-1:0] SCR_B = SCR_WORD;

  logic [WIN-1:0]        win;
  logic [BW-1:0][SW-1:0] scores;
  logic                  any_hit;
  logic [KW-1:0]         best_k;
  logic [SW-1:0]         best_s;
  logic                  lock_hit;
  logic [KW-1:0]         ksel;
  logic [BW-1:0]         aligned;

  sync_st_e      st, nst;
  logic [CW-1:0] cnt, ncnt;
  logic [KW-1:0] ck, nck;
  logic          miss_q, nmiss;
  logic          emit, first;
  logic          acc;
  logic [SIW-1:0] sidx;

  assign s_ready = !m_valid || m_ready;
  assign acc     = s_valid && s_ready;

  // eight offset correlators over the registered window
  for (genvar g = 0; g < BW; g++) begin : g_corr
    psync_corr #(.PW(PRE_BITS), .SW(SW), .PATTERN(PRE_WORD)) u_corr (
      .slice (win[WIN-1-g -: PRE_BITS]),
      .score (scores[g])
    );
  end

  psync_pick #(.N(BW), .SW(SW), .KW(KW)) u_pick (
    .scores (scores),
    .thr    (thr),
    .hit    (any_hit),
    .best_k (best_k),
    .best_s (best_s)
  );

  assign lock_hit = (scores[ck] >= thr);
  assign ksel     = (st == ST_TRACK) ? ck : best_k;

  psync_shift #(.BW(BW), .KW(KW)) u_shift (
    .bits ({win[BW-1:0], s_data}),
    .k    (ksel),
    .q    (aligned)
  );

  always_comb begin
    nst   = st;
    ncnt  = cnt;
    nck   = ck;
    nmiss = miss_q;
    emit  = 1'b0;
    first = 1'b0;
    if (acc) begin
      if (st != ST_HUNT && cnt < FRAME_C) ncnt = cnt + 1'b1;
      unique case (st)
        ST_HUNT: begin
          if (any_hit) begin
            nst  = ST_CONFIRM;
            nck  = best_k;
            ncnt = CW'(1);
          end
        end
        ST_CONFIRM: begin
          if (cnt == FRAME_C && any_hit && best_k == ck) begin
            nst   = ST_TRACK;
            ncnt  = CW'(1);
            nmiss = 1'b0;
            emit  = 1'b1;
            first = 1'b1;
          end else if (any_hit) begin
            nck  = best_k;
            ncnt = CW'(1);
          end else if (cnt == FRAME_C) begin
            nst  = ST_HUNT;
            ncnt = '0;
          end
        end
        ST_TRACK: begin
          if (cnt == FRAME_C) begin
            if (!lock_hit && miss_q) begin
              nst   = ST_HUNT;
              ncnt  = '0;
              nmiss = 1'b0;
            end else begin
              nmiss = !lock_hit;
              ncnt  = CW'(1);
              emit  = 1'b1;
              first = 1'b1;
            end
          end else if (cnt < DATA_C) begin
            emit = 1'b1;
          end
        end
        default: nst = ST_HUNT;
      endcase
    end
  end

  assign sidx = first ? '0 : cnt[SIW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win     <= '0;
      st      <= ST_HUNT;
      cnt     <= '0;
      ck      <= '0;
      miss_q  <= 1'b0;
      m_valid <= 1'b0;
      m_data  <= '0;
      m_sof   <= 1'b0;
    end else begin
      if (acc) win <= {win[WIN-BW-1:0], s_data};
      st     <= nst;
      cnt    <= ncnt;
      ck     <= nck;
      miss_q <= nmiss;
      if (acc && emit) begin
        m_valid <= 1'b1;
        m_data  <= aligned ^ SCR_B[SIW'(SCR_N-1) - sidx];
        m_sof   <= first;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end

  assign locked    = (st == ST_TRACK);
  assign align_off = ck;

  // R9: stalled output is frozen
  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_sof));

  // R4: bytes only appear while locked
  a_r4_out_locked: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> locked);

  // R3: entering lock presents the first frame byte
  a_r3_lock_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> m_valid && m_sof);

  // R8: lock falls only after a remembered miss
  a_r8_drop_two: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(miss_q));

  // R3: frame counter stays within one frame
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FRAME_C);

  // R2: selected score dominates every correlator
  for (genvar g = 0; g < BW; g++) begin : g_chk
    a_r2_best_score: assert property (@(posedge clk) disable iff (!rst_n)
      best_s >= scores[g]);
  end
endmodule

// File: tb/sim_pre_align.sv
module sim_pre_align;
  localparam logic [31:0] PRE = 32'hE4A62F1D;
  localparam logic [31:0] SCR = 32'h9B3CD058;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] thr;
  logic       s_valid, s_ready, m_valid, m_ready, m_sof, locked;
  logic [7:0] s_data, m_data;
  logic [2:0] align_off;

  always #10 clk = ~clk;

  pre_align #(.PRE_WORD(PRE), .SCR_WORD(SCR)) u0 (
    .clk, .rst_n, .thr, .s_valid, .s_ready, .s_data,
    .m_valid, .m_ready, .m_data, .m_sof, .locked, .align_off
  );

  int   n_chk = 0, n_bad = 0;
  bit   bq[$];
  logic [8:0] expq[$], gotq[$];
  logic [15:0] lf = 16'hACE1;
  int   hold_bad, rdy_bad;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(int f, int j);
    logic [31:0] x;
    x = 32'(f * 7919 + j * 104729 + 12345);
    x ^= x << 13;
    x ^= x >> 17;
    x ^= x << 5;
    return x[15:8];
  endfunction

  task automatic put_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) bq.push_back(b[i]);
  endtask

  // one frame: preamble (with error mask) then 256 scrambled payload bytes
  task automatic put_frame(int f, logic [31:0] err, bit expect_out);
    for (int i = 31; i >= 0; i--) bq.push_back(PRE[i] ^ err[i]);
    for (int j = 0; j < 256; j++) begin
      logic [7:0] d;
      d = dbyte(f, j);
      put_byte(d ^ SCR[31 - 8 * (j % 4) -: 8]);
      if (expect_out) expq.push_back({(j == 0), d});
    end
  endtask

  task automatic do_reset(logic [5:0] t);
    @(negedge clk);
    rst_n = 1'b0; s_valid = 1'b0; s_data = '0; m_ready = 1'b1; thr = t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic begin_case(logic [5:0] t, int lead_bits);
    do_reset(t);
    bq.delete(); expq.delete(); gotq.delete();
    hold_bad = 0; rdy_bad = 0;
    for (int i = 0; i < 48 + lead_bits; i++) bq.push_back(1'b0);
  endtask

  task automatic feed(bit stall);
    int idx = 0, drain = 0, nb;
    bit prev_stall = 0;
    logic [8:0] prev = '0;
    nb = bq.size() / 8;
    while (idx < nb || drain < 20) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      m_ready = stall ? (lf[0] | lf[3]) : 1'b1;
      if (idx < nb) begin
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[7 - i] = bq[idx * 8 + i];
        s_valid = stall ? !(lf[5] & lf[6]) : 1'b1;
        s_data  = b;
      end else begin
        s_valid = 1'b0;
        drain++;
      end
      #1;
      if (prev_stall && (!m_valid || {m_sof, m_data} != prev)) hold_bad++;
      if (s_ready !== (!m_valid || m_ready)) rdy_bad++;
      if (m_valid && m_ready) gotq.push_back({m_sof, m_data});
      prev_stall = m_valid && !m_ready;
      prev = {m_sof, m_data};
      if (s_valid && s_ready) idx++;
    end
  endtask

  task automatic end_case(string req, bit exp_lock, int exp_k, bit stall);
    int bad_at = -1;
    while (bq.size() % 8 != 0) bq.push_back(1'b0);
    put_byte(8'h00);
    feed(stall);
    chk(gotq.size() == expq.size(), req, "output byte count", gotq.size(), expq.size());
    for (int i = 0; i < gotq.size() && i < expq.size(); i++)
      if (bad_at < 0 && gotq[i] != expq[i]) bad_at = i;
    chk(bad_at < 0, req, "R5/R6/R7 byte and start flag",
        (bad_at < 0) ? 0 : int'(gotq[bad_at]), (bad_at < 0) ? 0 : int'(expq[bad_at]));
    chk(locked == exp_lock, req, "lock flag", locked, exp_lock);
    if (exp_lock) chk(align_off == exp_k, req, "R2 offset", align_off, exp_k);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; s_valid = 1'b0; s_data = '0; m_ready = 1'b1; thr = 6'd30;
    do_reset(6'd30);
    #1;
    // R10: reset state
    chk(m_valid == 1'b0, "R10", "m_valid", m_valid, 0);
    chk(locked == 1'b0, "R10", "locked", locked, 0);
    chk(s_ready == 1'b1, "R10", "s_ready", s_ready, 1);

    // R1 R2 R5 R6 R7: offset sweep, lock on second preamble
    for (int k = 0; k < 8; k++) begin
      begin_case((k % 2 == 0) ? 6'd30 : 6'd29, k);
      put_frame(1, '0, 1'b0);
      put_frame(2, '0, 1'b1);
      put_frame(3, '0, 1'b1);
      end_case("R2", 1'b1, k, 1'b0);
    end

    // R1: two bit errors pass at threshold 30
    begin_case(6'd30, 3);
    put_frame(4, 32'h01000010, 1'b0);
    put_frame(5, 32'h01000010, 1'b1);
    end_case("R1", 1'b1, 3, 1'b0);

    // R1: same stream fails at threshold 31, R4 nothing emitted
    begin_case(6'd31, 3);
    put_frame(4, 32'h01000010, 1'b0);
    put_frame(5, 32'h01000010, 1'b0);
    end_case("R1", 1'b0, 0, 1'b0);

    // R3: wrong distance replaces the candidate, lock one frame later
    begin_case(6'd30, 1);
    put_frame(6, '0, 1'b0);
    put_byte(8'h3C);
    put_frame(7, '0, 1'b0);
    put_frame(8, '0, 1'b1);
    end_case("R3", 1'b1, 1, 1'b0);

    // R3: right distance but other offset, lock on offset 5 later
    begin_case(6'd30, 2);
    put_frame(9, '0, 1'b0);
    for (int i = 0; i < 3; i++) bq.push_back(1'b1);
    put_frame(10, '0, 1'b0);
    put_frame(11, '0, 1'b1);
    end_case("R3", 1'b1, 5, 1'b0);

    // R8: single misses tolerated, two in a row drop lock
    begin_case(6'd30, 6);
    put_frame(12, '0, 1'b0);
    put_frame(13, '0, 1'b1);
    put_frame(14, 32'hFF000000, 1'b1);
    put_frame(15, '0, 1'b1);
    put_frame(16, 32'h00FF0000, 1'b1);
    put_frame(17, 32'h0000FF00, 1'b0);
    end_case("R8", 1'b0, 0, 1'b0);

    // R9: random stalls on both sides
    begin_case(6'd30, 4);
    put_frame(18, '0, 1'b0);
    put_frame(19, '0, 1'b1);
    put_frame(20, '0, 1'b1);
    end_case("R9", 1'b1, 4, 1'b1);
    chk(hold_bad == 0, "R9", "stalled byte changed", hold_bad, 0);
    chk(rdy_bad == 0, "R9", "s_ready rule", rdy_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule